// File: doc/BRIEF.md
# Iterative Montgomery Modular Multiplier

This block forms the Montgomery product of two 32-bit operands: for operands X and Y and an odd modulus N it returns X·Y·2^-32 mod N. It is the inner kernel of modular exponentiation engines that keep their values in the Montgomery domain. Moving values into or out of that domain is left to the caller.

The caller drives X, Y and N, waits one clock and then raises and holds `start_i`. On the first clock edge that sees the level high, the block copies the operands into internal registers. It then runs one radix-2 reduction step per clock, scanning X from bit 0 upward, and makes a single conditional subtraction of N at the end. After that it raises `ready_o` with the result on `product_o`. Dropping `start_i` returns the block to idle on the next edge, whether the operation had finished or not. The block has no reset pin. A clock edge with `start_i` low acts as the clear, so after power-up the caller must give at least one such edge before the first operation.

Top module: `mont_mul_iter`

## Requirements
- R1: While `start_i` is low, `ready_o` reads 0 from the first clock edge onward.
- R2: For odd N with X < N and Y < N, the result P satisfies P·2^32 ≡ X·Y (mod N), with X on `opa_i`, Y on `opb_i` and N on `mod_i`.
- R3: The result is always strictly below N.
- R4: `ready_o` rises on the 34th clock edge counted from the edge that first sees `start_i` high (WIDTH+2 edges, where that first edge is number 1).
- R5: Changes to `opa_i`, `opb_i` and `mod_i` after the capture edge have no effect on the result.
- R6: While `start_i` stays high after completion, `ready_o` stays 1 and `product_o` does not change.
- R7: `ready_o` is 0 after the first clock edge that sees `start_i` low. A new operation whose operands were applied one clock before `start_i` rises gives its own correct result.
- R8: The largest legal operands (N = 0xFFFFFFFF, X = Y = 0xFFFFFFFE) give the correct result, so no carry is lost in the accumulator.
- R9: Dropping `start_i` before `ready_o` rises aborts the operation. `ready_o` stays low, and the next operation takes the full latency of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| start_i | input | 1 | Operation request level; low clears the block to idle |
| opa_i | input | WIDTH | First operand X, scanned from bit 0 upward |
| opb_i | input | WIDTH | Second operand Y |
| mod_i | input | WIDTH | Odd modulus N |
| product_o | output | WIDTH | Montgomery product X·Y·2^-WIDTH mod N |
| ready_o | output | 1 | Result valid; held until `start_i` falls |

## Verification
Each result is due exactly 34 clock edges after `start_i` rises. The first of those edges captures the operands, the next 32 perform the reduction steps, and the last registers the subtracted result together with `ready_o`. The driver stamps the bench cycle count when it raises `start_i` and queues the expected value. The monitor samples on falling edges, and on the first falling edge where `ready_o` is high it pops the entry and requires the elapsed count to be exactly 34. The clearing of `ready_o` is due one edge after `start_i` falls, and the driver checks it at the falling edge that follows.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_DONE = 2'd3
  } mm_state_e;

endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  mm_state_e        state_q;
  logic [CNT_W-1:0] step_cnt_q;

  // A low start level is the only clear: it parks the sequencer in idle.
  always_ff @(posedge clk_i) begin
    if (!start_i) begin
      state_q    <= ST_IDLE;
      step_cnt_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_q    <= ST_RUN;
          step_cnt_q <= '0;
        end
        ST_RUN: begin
          if (step_cnt_q == LAST_STEP) begin
            state_q <= ST_FIN;
          end
          step_cnt_q <= step_cnt_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_DONE;
        default: state_q <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    load_o = start_i && (state_q == ST_IDLE);
    step_o = start_i && (state_q == ST_RUN);
    fin_o  = start_i && (state_q == ST_FIN);
  end

endmodule

// File: rtl/mm_step.sv
// One radix-2 Montgomery step: add Y when the scanned bit is set, add N
// when the partial sum is odd, then halve. With acc < 2N the output stays
// below 2N, and the widest intermediate is below 4N, which fits WIDTH+2 bits.
module mm_step #(
  parameter int WIDTH = 32,
  localparam int ACC_W = WIDTH + 2
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [WIDTH-1:0] mod_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] with_b;
  logic [ACC_W-1:0] with_m;

  always_comb begin
    with_b = acc_i + (bit_i ? {2'b00, opb_i} : '0);
    with_m = with_b + (with_b[0] ? {2'b00, mod_i} : '0);
    acc_o  = with_m >> 1;
  end

endmodule

// File: rtl/mm_reduce.sv
// Final correction: the accumulator arrives below 2N, one subtraction suffices.
module mm_reduce #(
  parameter int WIDTH = 32,
  localparam int ACC_W = WIDTH + 2
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [WIDTH-1:0] mod_i,
  output logic [WIDTH-1:0] res_o
);

  logic [ACC_W-1:0] diff;
  logic             ge;

  always_comb begin
    diff  = acc_i - {2'b00, mod_i};
    ge    = acc_i >= {2'b00, mod_i};
    res_o = ge ? diff[WIDTH-1:0] : acc_i[WIDTH-1:0];
  end

endmodule

// File: rtl/mont_mul_iter.sv
module mont_mul_iter #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             start_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [WIDTH-1:0] mod_i,
  output logic [WIDTH-1:0] product_o,
  output logic             ready_o
);

  localparam int ACC_W = WIDTH + 2;

  logic             load, step, fin;
  logic [WIDTH-1:0] a_q, b_q, m_q;
  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic [WIDTH-1:0] res;
  logic [WIDTH-1:0] product_q;
  logic             ready_q;

  mm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin)
  );

  mm_step #(.WIDTH(WIDTH)) u_step (
    .acc_i(acc_q),
    .opb_i(b_q),
    .mod_i(m_q),
    .bit_i(a_q[0]),
    .acc_o(acc_nxt)
  );

  mm_reduce #(.WIDTH(WIDTH)) u_reduce (
    .acc_i(acc_q),
    .mod_i(m_q),
    .res_o(res)
  );

  // Operand capture and iteration; X is shifted so bit 0 is always the next bit.
  always_ff @(posedge clk_i) begin
    if (load) begin
      a_q   <= opa_i;
      b_q   <= opb_i;
      m_q   <= mod_i;
      acc_q <= '0;
    end else if (step) begin
      a_q   <= a_q >> 1;
      acc_q <= acc_nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fin) begin
      product_q <= res;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!start_i) begin
      ready_q <= 1'b0;
    end else if (fin) begin
      ready_q <= 1'b1;
    end
  end

  assign product_o = product_q;
  assign ready_o   = ready_q;

endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             start_i,
  input logic             ready_i,
  input logic [WIDTH-1:0] product_i,
  input logic [WIDTH-1:0] mod_q_i
);

  localparam int LAT   = WIDTH + 2;
  localparam int LAT_W = $clog2(LAT + 2);

  // Edges seen with start high since it last was low, saturating.
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i) begin
    if (!start_i) begin
      lat_q <= '0;
    end else if (lat_q != LAT_W'(LAT + 1)) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  a_r1_idle_no_ready: assert property (@(posedge clk_i)
    !start_i |=> !ready_i);

  a_r3_below_modulus: assert property (@(posedge clk_i) disable iff (!start_i)
    ready_i |-> (product_i < mod_q_i));

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!start_i)
    $rose(ready_i) |-> (lat_q == LAT_W'(LAT)));

  a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (!start_i)
    (ready_i && start_i) |=> (ready_i && $stable(product_i)));

  a_r7_drop_clears: assert property (@(posedge clk_i)
    $fell(start_i) |=> !ready_i);

endmodule

bind mont_mul_iter mm_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .start_i  (start_i),
  .ready_i  (ready_o),
  .product_i(product_o),
  .mod_q_i  (m_q)
);

// File: tb/mont_mul_iter_tb.sv
`timescale 1ns/1ps
module mont_mul_iter_tb;

  localparam int W   = 32;
  localparam int LAT = W + 2;

  typedef struct {
    logic [W-1:0] val;
    int           cyc0;
    logic [W-1:0] m;
  } exp_t;

  logic         clk = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opa = '0, opb = '0, modn = '1;
  logic [W-1:0] product;
  logic         ready;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  mont_mul_iter #(.WIDTH(W)) u_dut (
    .clk_i    (clk),
    .start_i  (start),
    .opa_i    (opa),
    .opb_i    (opb),
    .mod_i    (modn),
    .product_o(product),
    .ready_o  (ready)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference: X*Y mod N, then halve modulo N W times.
  function automatic logic [W-1:0] mont_ref(input logic [W-1:0] x, y, n);
    logic [63:0] v;
    v = ({32'd0, x} * {32'd0, y}) % {32'd0, n};
    for (int i = 0; i < W; i++) begin
      v = v[0] ? ((v + {32'd0, n}) >> 1) : (v >> 1);
    end
    return v[W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares each completed result against the scoreboard.
  logic rdy_d = 1'b0;
  always @(negedge clk) begin
    if (ready && !rdy_d) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected ready", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(product == e.val, "R2", "product", product, e.val);
        check(product < e.m, "R3", "product below modulus", product, e.m);
        check(cyc - e.cyc0 == LAT, "R4", "latency", cyc - e.cyc0, LAT);
      end
    end
    rdy_d = ready;
  end

  // Driver: applies operands, raises start one clock later, queues expectation.
  task automatic run_op(input logic [W-1:0] a, b, m, input int mutate_at,
                        input int hold, input int abort_at);
    int n;
    logic [W-1:0] p0;
    @(negedge clk); opa = a; opb = b; modn = m;
    @(negedge clk); start = 1'b1;
    if (abort_at == 0) exp_q.push_back('{mont_ref(a, b, m), cyc, m});
    n = 0;
    while (!ready && n < 200 && !(abort_at > 0 && n == abort_at)) begin
      @(negedge clk); n++;
      if (n == mutate_at) begin
        opa = ~a; opb = ~b; modn = ~m | 32'd1;   // R5: late changes ignored
      end
    end
    if (abort_at > 0) begin
      check(!ready, "R9", "no ready before abort", ready, 0);
      start = 1'b0;
      @(negedge clk);
      check(!ready, "R9", "ready after abort", ready, 0);
      return;
    end
    if (n >= 200) check(1'b0, "R4", "ready timeout", n, LAT);
    p0 = product;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(ready && product == p0, "R6", "held result", product, p0);
    end
    start = 1'b0;
    @(negedge clk);
    check(!ready, "R7", "ready after start low", ready, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!ready, "R1", "idle ready", ready, 0);
    // R2: stated vectors, checked against literal values too
    check(mont_ref(32'h40000003, 32'h6FD9C737, 32'h8000000B) == 32'h66E4624E,
          "R2", "reference vector 1", 0, 32'h66E4624E);
    run_op(32'h40000003, 32'h6FD9C737, 32'h8000000B, 0, 2, 0);
    run_op(32'h40000002, 32'h6FD9C736, 32'h8000000B, 0, 0, 0);
    // R7: back-to-back with operands applied one clock before start
    run_op(32'h12345678, 32'h0BADF00D, 32'hF0000001, 0, 0, 0);
    // R3: small modulus, result reduced below N
    run_op(32'd12, 32'd11, 32'd13, 0, 1, 0);
    run_op(32'd0, 32'd7, 32'd13, 0, 0, 0);
    // R8: widest operands
    run_op(32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFF, 0, 0, 0);
    // R5: operands changed mid-computation
    run_op(32'h7FFFFFFF, 32'h55555555, 32'hC0000003, 5, 0, 0);
    // R6: long hold after completion
    run_op(32'h00000001, 32'h00000001, 32'h8000000B, 0, 10, 0);
    // R9: abort then full operation
    run_op(32'h40000003, 32'h6FD9C737, 32'h8000000B, 0, 0, 12);
    run_op(32'h3C3C3C3C, 32'h2A2A2A2A, 32'hE1234567, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 0);
    check(!ready, "R1", "final idle ready", ready, 0);
    finish_run();
  end

endmodule